// File: doc/BRIEF.md
# Quadrature Position Decoder with Index Zeroing

This block turns a pair of already-synchronised encoder phase signals into a signed 32-bit position. Every change on either phase is counted, so each full cycle of the four phase states moves the position by four. The direction of each count comes from the order in which the phases change. An optional index input, chosen from a bank of general digital lines, returns the position to zero whenever it is seen high at the moment a phase changes.

The block is controlled through two command strobes, one per channel, that share one 16-bit data word. Both channels drive one shared position. A written word sets the index configuration. A word of zero also clears the position. A read strobe captures the position into two output ports that always carry the same value. A read that lands on the same clock edge as a clear captures the value from before the clear. A transition that skips a state is not counted and is reported on a one-cycle error output.

Top module: `quad_pos_decoder`

## Requirements
- R1: With the phase state written as {A,B}, the order 00→01→11→10→00 adds one per step and the reverse order subtracts one per step. The count is applied on the clock edge that first samples the new state. Four forward steps add exactly four.
- R2: A change of both phases in one sample (00↔11 or 01↔10) leaves the position unchanged. It drives `trans_err` high for exactly the one cycle that follows that edge.
- R3: A `rd_stb` edge captures the position into both `rd_pos_a` and `rd_pos_b`, which are always equal. They hold that value until the next `rd_stb`.
- R4: A write of 0x0000 on either bit of `cmd_wr` clears the position on that edge. Reads that follow return zero until a new count occurs.
- R5: A read on the same edge as a clearing write returns the position from just before the clear.
- R6: Any write stores the configuration: bit 15 enables the index and bits 4:0 select the index line, so 0x800B selects line 11. The new configuration applies from the edge after the write.
- R7: With the index enabled, an edge of either phase that finds the selected line high sets the position to zero, in place of that edge's step. The line is ignored on cycles with no phase change.
- R8: With the index disabled, the index line has no effect on the position.
- R9: The position wraps modulo 2^32 in both directions. One reverse step from 0 gives 0xFFFFFFFF, and one forward step from there gives 0.
- R10: After reset the position, both read ports and `trans_err` are zero. The phase state present during reset is taken as the starting state and is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ph_a | input | 1 | Phase A, already synchronised |
| ph_b | input | 1 | Phase B, already synchronised |
| io_lines | input | 32 | Digital lines from which the index input is selected |
| cmd_wr | input | 2 | Command write strobe, one bit per channel |
| cmd_data | input | 16 | Command and configuration word shared by both channels |
| rd_stb | input | 1 | Read strobe that captures the position |
| rd_pos_a | output | 32 | Captured position, channel A port |
| rd_pos_b | output | 32 | Captured position, channel B port |
| trans_err | output | 1 | One-cycle pulse after an illegal phase transition |

## Verification
Each phase step, clear and index hit changes the internal position on the edge that samples it. That position is only visible through a read, so the bench checks it from the outputs of a `rd_stb` issued on a later cycle, sampled on the falling edge after that read's rising edge. `trans_err` and the captured read values are due one rising edge after their cause. The bench drives every input on a falling edge, updates its reference model for the rising edge that follows, and compares on the next falling edge. A read in the same cycle as a clear or a phase step is therefore compared with the model's value from before that edge.

// File: rtl/quad_pkg.sv
// Package: shared types and helpers for the quadrature position decoder.
// Assumes phase inputs are already synchronised to the system clock.
package quad_pkg;

    // Classification of one sampled phase transition.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_FWD  = 2'd1,
        STEP_REV  = 2'd2,
        STEP_BAD  = 2'd3
    } step_t;

    // Position along the Gray cycle 00,01,11,10 for state {A,B}.
    function automatic logic [1:0] gray_rank(input logic [1:0] ab);
        logic [1:0] r;
        case (ab)
            2'b00:   r = 2'd0;
            2'b01:   r = 2'd1;
            2'b11:   r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

    // Maps the rank difference between two states to a step class.
    function automatic step_t classify(input logic [1:0] prev_ab,
                                       input logic [1:0] cur_ab);
        logic [1:0] diff;
        step_t s;
        diff = gray_rank(cur_ab) - gray_rank(prev_ab);
        case (diff)
            2'd0:    s = STEP_NONE;
            2'd1:    s = STEP_FWD;
            2'd3:    s = STEP_REV;
            default: s = STEP_BAD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/quad_phase_track.sv
// Module: quad_phase_track
// Keeps the previously sampled {A,B} state and classifies each new sample
// as no change, forward, reverse or illegal. Step output is combinational
// on the current inputs; the error flag is a registered one-cycle pulse.
// Assumes ph_a/ph_b are synchronous to clk. During reset the stored state
// follows the inputs so the state at reset release is never counted.
module quad_phase_track
    import quad_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ph_a,
    input  logic  ph_b,
    output step_t step_o,
    output logic  edge_o,
    output logic  err_o
);

    logic [1:0] prev_q;
    logic [1:0] cur_ab;

    assign cur_ab = {ph_a, ph_b};

    // Classify the transition from the stored state to the present sample.
    always_comb begin
        step_o = classify(prev_q, cur_ab);
        edge_o = (step_o != STEP_NONE);
    end

    // Remember the last sampled phase state (tracks inputs during reset).
    always_ff @(posedge clk) begin
        prev_q <= cur_ab;
    end

    // Raise the error flag for one cycle after an illegal transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else begin
            err_o <= (step_o == STEP_BAD);
        end
    end

    assert_err_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == STEP_BAD) |=> err_o);

    assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o != STEP_BAD) |=> !err_o);

endmodule

// File: rtl/quad_index_cfg.sv
// Module: quad_index_cfg
// Holds the index configuration (enable bit and line select) written through
// either channel's command strobe, selects the index line from the bank and
// flags a clearing write (data word of zero). A written configuration acts
// from the next edge on. Assumes both strobes carry the same data word.
module quad_index_cfg #(
    parameter int CMD_W  = 16,
    parameter int LINE_N = 32,
    parameter int EN_BIT = 15,
    parameter int NCH    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    wr_i,
    input  logic [CMD_W-1:0]  data_i,
    input  logic [LINE_N-1:0] lines_i,
    output logic              clr_o,
    output logic              en_o,
    output logic              z_o
);

    localparam int SEL_W = (LINE_N > 1) ? $clog2(LINE_N) : 1;

    logic             any_wr;
    logic             en_q;
    logic [SEL_W-1:0] sel_q;

    // Any channel strobe counts as one write of the shared word.
    always_comb begin
        any_wr = |wr_i;
        clr_o  = any_wr && (data_i == '0);
    end

    // Store enable and line select from each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (any_wr) begin
            en_q  <= data_i[EN_BIT];
            sel_q <= data_i[SEL_W-1:0];
        end
    end

    assign en_o = en_q;

    // Pick the index line; out-of-range selections read as low.
    generate
        if (LINE_N == (1 << SEL_W)) begin : g_full
            assign z_o = lines_i[sel_q];
        end else begin : g_partial
            always_comb begin
                if ({1'b0, sel_q} < (SEL_W+1)'(LINE_N)) begin
                    z_o = lines_i[sel_q];
                end else begin
                    z_o = 1'b0;
                end
            end
        end
    endgenerate

    assert_cfg_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_i) |=> (en_o == $past(data_i[EN_BIT])));

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|wr_i) |=> $stable(en_o));

endmodule

// File: rtl/quad_pos_acc.sv
// Module: quad_pos_acc
// Signed position accumulator. Priority per edge: clearing write, then
// index zeroing, then the forward or reverse step. Illegal steps hold.
// Wraps modulo 2^POS_W with no saturation.
module quad_pos_acc
    import quad_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_t            step_i,
    input  logic             clr_i,
    input  logic             zero_i,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [POS_W-1:0] ONE = {{(POS_W-1){1'b0}}, 1'b1};

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;

    // Choose the next position by priority.
    always_comb begin
        if (clr_i || zero_i) begin
            pos_d = '0;
        end else begin
            case (step_i)
                STEP_FWD: pos_d = pos_q + ONE;
                STEP_REV: pos_d = pos_q - ONE;
                default:  pos_d = pos_q;
            endcase
        end
    end

    // Register the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos_o = pos_q;

    assert_fwd_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_FWD && !clr_i && !zero_i) |=> (pos_o == $past(pos_o) + ONE));

    assert_rev_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_REV && !clr_i && !zero_i) |=> (pos_o == $past(pos_o) - ONE));

    assert_bad_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_BAD && !clr_i && !zero_i) |=> $stable(pos_o));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pos_o == '0));

endmodule

// File: rtl/quad_pos_decoder.sv
// Module: quad_pos_decoder (top)
// 4x quadrature decoder with optional index zeroing. Two command channels
// share one position; a read strobe captures it into two identical ports.
// A capture on the same edge as a clear returns the pre-clear value.
// Assumes ph_a, ph_b and io_lines are already synchronous to clk.
module quad_pos_decoder #(
    parameter int POS_W  = 32,
    parameter int CMD_W  = 16,
    parameter int LINE_N = 32,
    parameter int EN_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph_a,
    input  logic              ph_b,
    input  logic [LINE_N-1:0] io_lines,
    input  logic [1:0]        cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              rd_stb,
    output logic [POS_W-1:0]  rd_pos_a,
    output logic [POS_W-1:0]  rd_pos_b,
    output logic              trans_err
);
    import quad_pkg::*;

    localparam int NCH = 2;

    step_t            step;
    logic             phase_edge;
    logic             clr;
    logic             idx_en;
    logic             idx_z;
    logic             zero_hit;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] rd_q [NCH];

    quad_phase_track u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_a   (ph_a),
        .ph_b   (ph_b),
        .step_o (step),
        .edge_o (phase_edge),
        .err_o  (trans_err)
    );

    quad_index_cfg #(
        .CMD_W  (CMD_W),
        .LINE_N (LINE_N),
        .EN_BIT (EN_BIT),
        .NCH    (NCH)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cmd_wr),
        .data_i  (cmd_data),
        .lines_i (io_lines),
        .clr_o   (clr),
        .en_o    (idx_en),
        .z_o     (idx_z)
    );

    // Index zeroing only on a phase edge while enabled.
    assign zero_hit = phase_edge && idx_en && idx_z;

    quad_pos_acc #(
        .POS_W (POS_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .clr_i  (clr),
        .zero_i (zero_hit),
        .pos_o  (pos)
    );

    // One capture register per channel port, loaded from the pre-edge position.
    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_rd
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rd_q[ch] <= '0;
                end else if (rd_stb) begin
                    rd_q[ch] <= pos;
                end
            end
        end
    endgenerate

    assign rd_pos_a = rd_q[0];
    assign rd_pos_b = rd_q[1];

    assert_ports_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pos_a == rd_pos_b);

    assert_read_preclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_pos_a == $past(pos)));

    assert_index_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_edge && idx_en && idx_z) |=> (pos == '0));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_edge && !clr) |=> $stable(pos));

endmodule

// File: tb/quad_pos_decoder_bench.sv
// Bench: directed corner cases plus seeded random walk, against a bench model.
module quad_pos_decoder_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ph_a = 1'b1;
    logic        ph_b = 1'b1;
    logic [31:0] io_lines = '0;
    logic [1:0]  cmd_wr = '0;
    logic [15:0] cmd_data = '0;
    logic        rd_stb = 1'b0;
    logic [31:0] rd_pos_a;
    logic [31:0] rd_pos_b;
    logic        trans_err;

    int errors = 0;
    int checks = 0;

    // Model state
    logic [31:0] m_pos = '0;
    logic [1:0]  m_prev = 2'b11;
    logic        m_en = 1'b0;
    logic [4:0]  m_sel = '0;
    logic [31:0] m_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_pos_decoder u_quad_pos_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_a      (ph_a),
        .ph_b      (ph_b),
        .io_lines  (io_lines),
        .cmd_wr    (cmd_wr),
        .cmd_data  (cmd_data),
        .rd_stb    (rd_stb),
        .rd_pos_a  (rd_pos_a),
        .rd_pos_b  (rd_pos_b),
        .trans_err (trans_err)
    );

    // Gray order position for {A,B}: 00,01,11,10.
    function automatic int ord(input logic [1:0] ab);
        if (ab == 2'b00) return 0;
        if (ab == 2'b01) return 1;
        if (ab == 2'b11) return 2;
        return 3;
    endfunction

    // Returns +1, -1, 0 (no change) or 2 (illegal).
    function automatic int step_of(input logic [1:0] p, input logic [1:0] c);
        int d;
        d = (ord(c) - ord(p) + 4) % 4;
        if (d == 1) return 1;
        if (d == 3) return -1;
        if (d == 2) return 2;
        return 0;
    endfunction

    // Next state forward (+1) or reverse (-1) from a state.
    function automatic logic [1:0] walk(input logic [1:0] p, input int dir);
        logic [1:0] seq [4];
        seq[0] = 2'b00; seq[1] = 2'b01; seq[2] = 2'b11; seq[3] = 2'b10;
        return seq[(ord(p) + dir + 4) % 4];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, model the rising edge, check at next falling edge.
    task automatic tick(input logic [1:0] ab, input logic [31:0] lines,
                        input logic [1:0] wr, input logic [15:0] data,
                        input logic rd, input string req);
        int s;
        logic bad;
        ph_a = ab[1]; ph_b = ab[0];
        io_lines = lines; cmd_wr = wr; cmd_data = data; rd_stb = rd;
        s = step_of(m_prev, ab);
        bad = (s == 2);
        if (rd) m_rd = m_pos;
        if ((|wr) && data == 16'h0000) m_pos = '0;
        else if (s != 0 && m_en && lines[m_sel]) m_pos = '0;
        else if (s == 1) m_pos = m_pos + 32'd1;
        else if (s == -1) m_pos = m_pos - 32'd1;
        if (|wr) begin m_en = data[15]; m_sel = data[4:0]; end
        m_prev = ab;
        @(posedge clk);
        @(negedge clk);
        check("R2 trans_err", {31'd0, trans_err}, {31'd0, bad});
        if (rd) begin
            check({req, " port a"}, rd_pos_a, m_rd);
            check("R3 port b", rd_pos_b, m_rd);
        end
    endtask

    task automatic idle_read(input string req);
        tick(m_prev, '0, 2'b00, 16'h0, 1'b1, req);
    endtask

    task automatic move(input int dir, input int n, input logic [31:0] lines);
        for (int i = 0; i < n; i++) tick(walk(m_prev, dir), lines, 2'b00, 16'h0, 1'b0, "R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // Reset with phase state 11 held; R10
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 port a after reset", rd_pos_a, 32'd0);
        check("R10 port b after reset", rd_pos_b, 32'd0);
        check("R10 err after reset", {31'd0, trans_err}, 32'd0);
        idle_read("R10 start state not counted");

        // R1 forward four then reverse two
        move(1, 4, '0);
        idle_read("R1 four forward");
        move(-1, 2, '0);
        idle_read("R1 two reverse");

        // R2 illegal jump: 11 -> 00 style two-bit change
        tick(~m_prev, '0, 2'b00, 16'h0, 1'b0, "R2");
        idle_read("R2 illegal holds count");
        check("R2 pulse ends", {31'd0, trans_err}, 32'd0);

        // R5 read with clear on channel a, then R4 reads zero
        tick(m_prev, '0, 2'b01, 16'h0000, 1'b1, "R5 read with clear");
        idle_read("R4 zero after clear");
        move(1, 3, '0);
        tick(m_prev, '0, 2'b10, 16'h0000, 1'b0, "R4");
        idle_read("R4 clear via channel b");

        // R9 wrap below zero and back
        move(-1, 1, '0);
        idle_read("R9 wrap to all ones");
        move(1, 1, '0);
        idle_read("R9 wrap back to zero");

        // R6 config write in same cycle as edge with line high: not yet active
        tick(walk(m_prev, 1), 32'h0000_0008, 2'b10, 16'h8003, 1'b0, "R6");
        idle_read("R6 config not active on write edge");
        move(1, 2, '0);
        move(1, 1, 32'h0000_0008);
        idle_read("R7 index zero on edge");

        // R7 via 0x800B, line 11; no edge means no effect; priority over step
        tick(m_prev, '0, 2'b01, 16'h800B, 1'b0, "R6");
        move(-1, 3, '0);
        for (int i = 0; i < 4; i++) tick(m_prev, 32'h0000_0800, 2'b00, 16'h0, 1'b0, "R7");
        idle_read("R7 line high without edge ignored");
        move(-1, 1, 32'h0000_0800);
        idle_read("R7 zero beats reverse step");

        // R8 index disabled: nonzero word with bit 15 clear
        tick(m_prev, '0, 2'b01, 16'h000B, 1'b0, "R6");
        move(1, 5, 32'h0000_0800);
        idle_read("R8 index disabled ignores line");

        // Seeded random walk
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [1:0] ab;
            logic [1:0] wr;
            logic [15:0] d;
            r = $urandom_range(0, 19);
            if (r < 8) ab = walk(m_prev, 1);
            else if (r < 14) ab = walk(m_prev, -1);
            else if (r < 19) ab = m_prev;
            else ab = ~m_prev;
            wr = 2'b00; d = 16'h0;
            if ($urandom_range(0, 59) == 0) begin
                wr = 2'($urandom_range(1, 3));
                case ($urandom_range(0, 2))
                    0: d = 16'h0000;
                    1: d = 16'h8000 | 16'($urandom_range(0, 31));
                    default: d = 16'($urandom_range(1, 31));
                endcase
            end
            tick(ab, $urandom & $urandom & $urandom & $urandom, wr, d,
                 ($urandom_range(0, 3) == 0), "R1 random");
        end
        idle_read("R1 random final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule